// File: doc/BRIEF.md
# Tower-field AES byte substitution

This block is the forward AES byte substitution for one byte, computed with arithmetic rather than read from a 256-entry table. The byte is mapped by an XOR network into a degree-two extension of GF(16). In that extension, the two coordinates are the coefficients on a pair of conjugate normal-basis elements. From there the multiplicative inverse needs only GF(16) operations: a norm, a 4-bit inverse and two 4-bit products. A second XOR network maps the result back to the byte domain and folds in the AES affine map.

The input network emits twelve shared terms: both coordinates and their sum. The norm stage and the output products read from this one vector. The norm is a single closed-form 4-bit expression that merges the squaring, the scaling constant and the cross product. The two products are left in a 5-bit redundant ring whose top bit stands for x^4 = x^3+x^2+x+1. The output network absorbs the fold back to four bits.

A parameter picks between two netlist styles. In the area style, shared terms are reused and the fold is explicit. In the speed style, every linear output is a flat parity of primary signals, and the 4-bit inverse is a sum of minterms. The block has no clock and no state. The output settles from the input alone.

Top module: `tfs_sbox`

## Requirements
- R1: For every input x, the output equals A·x^-1 XOR 0x63. Here x^-1 is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, and output bit i is q[i]^q[i+4]^q[i+5]^q[i+6]^q[i+7] (indices mod 8) of the inverse q.
- R2: Input 0x00 is given a zero inverse, so the output is 0x63.
- R3: Spot values hold: 0x01 gives 0x7C, 0x53 gives 0xED, 0x80 gives 0xCD, 0xFF gives 0x16.
- R4: No input maps to itself, and no input maps to its bitwise complement.
- R5: The 256 outputs are pairwise distinct.
- R6: The area style (STYLE = STYLE_AREA) and the speed style (STYLE = STYLE_SPEED) give identical outputs for all 256 inputs.
- R7: The output follows a change of input with no clock edge in between.
- R8: The input network sends only the zero byte to the all-zero coordinate pair.
- R9: The norm stage returns zero exactly when both coordinates are zero.
- R10: The 4-bit inverse v of a nonzero d satisfies d·v = 1 in GF(16), and d = 0 gives v = 0.
- R11: A zero norm inverse drives the output to the affine constant 0x63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_i | input | 8 | Byte to substitute |
| sbox_o | output | 8 | Substituted byte |

## Verification
The zero input is the main hazard. A design that fed zero into a true inversion, or that dropped the affine constant, would return 0x00 or some other value in place of 0x63. A wrong column in either linear network, or a mistake in the redundant fold, breaks only some of the 256 bytes. For that reason every byte is compared against a brute-force reference, and the outputs are also checked for being a permutation with no fixed points. The two netlist styles run side by side, so a fault that shows in only one style is caught. The input is also changed away from any clock edge, so that a design holding hidden state would fail the check.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic {STYLE_AREA = 1'b0, STYLE_SPEED = 1'b1} style_e;

  localparam int unsigned SUB_W     = 4;
  localparam int unsigned RED_W     = SUB_W + 1;
  localparam int unsigned BYTE_W    = 2 * SUB_W;
  localparam int unsigned SHARE_W   = 3 * SUB_W;
  localparam int unsigned SUB_N     = 1 << SUB_W;
  localparam int unsigned BYTE_N    = 1 << BYTE_W;
  localparam logic [8:0]  AES_POLY  = 9'h11B;
  localparam logic [7:0]  AFF_C     = 8'h63;
  localparam logic [7:0]  GEN       = 8'h03;
  localparam int unsigned OMEGA_EXP = 51;   // 255/5: element of order five

  typedef logic [SUB_W-1:0] sub_t;
  typedef logic [RED_W-1:0] red_t;
  typedef logic [SHARE_W-1:0][BYTE_W-1:0]  in_rows_t;
  typedef logic [BYTE_W-1:0][2*RED_W-1:0]  out_rows_red_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0]   out_rows_sub_t;
  typedef logic [2*RED_W-1:0][BYTE_W-1:0]  img_t;
  typedef logic [SUB_W-1:0][SUB_N-1:0]     inv_mask_t;

  // ---- GF(16) as GF(2)[x]/(x^4+x^3+x^2+x+1), redundant ring mod x^5+1 ----
  function automatic red_t red_mul(input sub_t x, input sub_t y);
    red_t r;
    r = '0;
    for (int i = 0; i < SUB_W; i++)
      for (int j = 0; j < SUB_W; j++)
        r[(i+j) % RED_W] = r[(i+j) % RED_W] ^ (x[i] & y[j]);
    return r;
  endfunction

  function automatic sub_t fold(input red_t r);
    return r[SUB_W-1:0] ^ {SUB_W{r[SUB_W]}};
  endfunction

  function automatic sub_t gf16_mul(input sub_t x, input sub_t y);
    return fold(red_mul(x, y));
  endfunction

  function automatic sub_t gf16_sq(input sub_t c);
    return {c[2], c[1] ^ c[2], c[3] ^ c[2], c[0] ^ c[2]};
  endfunction

  function automatic inv_mask_t inv_masks();
    inv_mask_t m;
    m = '0;
    for (int v = 1; v < SUB_N; v++)
      for (int t = 1; t < SUB_N; t++)
        if (gf16_mul(v[SUB_W-1:0], t[SUB_W-1:0]) == sub_t'(1))
          for (int b = 0; b < SUB_W; b++)
            m[b][v] = t[b];
    return m;
  endfunction

  // ---- GF(2^8) helpers used only for deriving the linear networks ----
  function automatic logic [7:0] gf256_mul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ AES_POLY[7:0]) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf256_pow(input logic [7:0] b, input int unsigned e);
    logic [7:0] r;
    r = 8'h01;
    for (int unsigned i = 0; i < e; i++) r = gf256_mul(r, b);
    return r;
  endfunction

  function automatic logic [7:0] find_root(input logic [7:0] w);
    logic [7:0] r;
    logic       hit;
    r   = '0;
    hit = 1'b0;
    for (int t = 0; t < 256; t++)
      if (!hit && ((gf256_mul(t[7:0], t[7:0]) ^ t[7:0] ^ w) == 8'h00)) begin
        r   = t[7:0];
        hit = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [7:0] aff_lin(input logic [7:0] v);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]};
  endfunction

  // images of w^k*Ybar (slot 0) and w^k*Y (slot 1), k = 0..RED_W-1
  function automatic img_t basis_imgs();
    img_t       r;
    logic [7:0] w, y, yb, wp;
    w  = gf256_pow(GEN, OMEGA_EXP);
    y  = find_root(w);            // Y^2 + Y + w = 0
    yb = y ^ 8'h01;               // conjugate: Y + Ybar = 1
    wp = 8'h01;
    for (int k = 0; k < RED_W; k++) begin
      r[k]         = gf256_mul(wp, yb);
      r[RED_W + k] = gf256_mul(wp, y);
      wp           = gf256_mul(wp, w);
    end
    return r;
  endfunction

  function automatic in_rows_t in_rows();
    img_t                         img;
    logic [BYTE_W-1:0][BYTE_W-1:0] col;
    logic [7:0]                   v;
    in_rows_t                     r;
    img = basis_imgs();
    col = '0;
    for (int c = 0; c < BYTE_N; c++) begin
      v = '0;
      for (int k = 0; k < SUB_W; k++) begin
        if (c[k])         v = v ^ img[k];
        if (c[SUB_W + k]) v = v ^ img[RED_W + k];
      end
      for (int j = 0; j < BYTE_W; j++)
        if (v == (8'h01 << j)) col[j] = c[BYTE_W-1:0];
    end
    for (int j = 0; j < BYTE_W; j++) begin
      for (int i = 0; i < BYTE_W; i++) r[i][j] = col[j][i];
      for (int i = 0; i < SUB_W; i++)  r[BYTE_W + i][j] = col[j][i] ^ col[j][SUB_W + i];
    end
    return r;
  endfunction

  function automatic out_rows_red_t out_rows_red();
    img_t          img;
    logic [7:0]    c;
    out_rows_red_t r;
    img = basis_imgs();
    for (int s = 0; s < 2*RED_W; s++) begin
      c = aff_lin(img[s]);
      for (int i = 0; i < BYTE_W; i++) r[i][s] = c[i];
    end
    return r;
  endfunction

  function automatic out_rows_sub_t out_rows_sub();
    img_t          img;
    logic [7:0]    c;
    out_rows_sub_t r;
    img = basis_imgs();
    for (int sl = 0; sl < 2; sl++)
      for (int k = 0; k < SUB_W; k++) begin
        c = aff_lin(img[sl*RED_W + k]);
        for (int i = 0; i < BYTE_W; i++) r[i][sl*SUB_W + k] = c[i];
      end
    return r;
  endfunction

endpackage

// File: rtl/tfs_in_map.sv
module tfs_in_map import tfs_pkg::*; #(
  parameter style_e STYLE = STYLE_SPEED
) (
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [SHARE_W-1:0] share_o  // {a^b, b, a}
);
  localparam in_rows_t ROWS = in_rows();

  if (STYLE == STYLE_SPEED) begin : g_flat
    for (genvar i = 0; i < SHARE_W; i++) begin : g_bit
      assign share_o[i] = ^(byte_i & ROWS[i]);
    end
  end else begin : g_reuse
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign share_o[i] = ^(byte_i & ROWS[i]);
    end
    assign share_o[SHARE_W-1:BYTE_W] = share_o[SUB_W-1:0] ^ share_o[BYTE_W-1:SUB_W];
  end

  always_comb begin
    a_r8_zero_only: assert ((byte_i == '0) == (share_o[BYTE_W-1:0] == '0))
      else $error("R8: nonzero byte collapsed to zero coordinates or vice versa");
  end
endmodule

// File: rtl/tfs_norm.sv
module tfs_norm import tfs_pkg::*; (
  input  logic [SHARE_W-1:0] share_i,
  output sub_t               norm_o
);
  sub_t a, b, s, sq_nu;
  red_t acc;

  assign a = share_i[SUB_W-1:0];
  assign b = share_i[BYTE_W-1:SUB_W];
  assign s = share_i[SHARE_W-1:BYTE_W];
  // (a+b)^2 * x in closed form: a bit permutation, no reduction needed
  assign sq_nu  = {s[1], s[3], s[0], s[2]};
  assign acc    = red_mul(a, b) ^ {1'b0, sq_nu};
  assign norm_o = fold(acc);

  always_comb begin
    a_r9_norm_zero: assert ((norm_o == '0) == (a == '0 && b == '0))
      else $error("R9: norm zero mismatch");
  end
endmodule

// File: rtl/tfs_sub_inv.sv
module tfs_sub_inv import tfs_pkg::*; #(
  parameter style_e STYLE = STYLE_SPEED
) (
  input  sub_t d_i,
  output sub_t inv_o
);
  if (STYLE == STYLE_SPEED) begin : g_sop
    localparam inv_mask_t MASKS = inv_masks();
    logic [SUB_N-1:0] hot;
    assign hot = SUB_N'(1) << d_i;
    for (genvar b = 0; b < SUB_W; b++) begin : g_bit
      assign inv_o[b] = |(hot & MASKS[b]);
    end
  end else begin : g_pow
    sub_t p2, p4, p8;
    assign p2    = gf16_sq(d_i);
    assign p4    = gf16_sq(p2);
    assign p8    = gf16_sq(p4);
    assign inv_o = gf16_mul(gf16_mul(p2, p4), p8);  // d^14
  end

  always_comb begin
    a_r10_inverse: assert (d_i == '0 || gf16_mul(d_i, inv_o) == sub_t'(1))
      else $error("R10: subfield inverse wrong");
    a_r10_zero: assert (d_i != '0 || inv_o == '0)
      else $error("R10: zero not mapped to zero");
  end
endmodule

// File: rtl/tfs_out_stage.sv
module tfs_out_stage import tfs_pkg::*; #(
  parameter style_e STYLE = STYLE_SPEED
) (
  input  sub_t              theta_i,
  input  sub_t              a_i,
  input  sub_t              b_i,
  output logic [BYTE_W-1:0] sbox_o
);
  red_t              z_yb, z_y;
  logic [BYTE_W-1:0] lin;

  assign z_yb = red_mul(theta_i, b_i);  // coefficient on Ybar
  assign z_y  = red_mul(theta_i, a_i);  // coefficient on Y

  if (STYLE == STYLE_SPEED) begin : g_flat
    localparam out_rows_red_t ROWS = out_rows_red();
    logic [2*RED_W-1:0] zz;
    assign zz = {z_y, z_yb};
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign lin[i] = ^(zz & ROWS[i]);
    end
  end else begin : g_fold
    localparam out_rows_sub_t ROWS = out_rows_sub();
    logic [BYTE_W-1:0] ff;
    assign ff = {fold(z_y), fold(z_yb)};
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign lin[i] = ^(ff & ROWS[i]);
    end
  end

  assign sbox_o = lin ^ AFF_C;

  always_comb begin
    a_r11_zero_theta: assert (theta_i != '0 || sbox_o == AFF_C)
      else $error("R11: zero inverse did not give affine constant");
  end
endmodule

// File: rtl/tfs_sbox.sv
module tfs_sbox import tfs_pkg::*; #(
  parameter style_e STYLE = STYLE_SPEED
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] sbox_o
);
  logic [SHARE_W-1:0] share;
  sub_t               norm, theta;

  tfs_in_map #(.STYLE(STYLE)) u_in (
    .byte_i (byte_i),
    .share_o(share)
  );

  tfs_norm u_norm (
    .share_i(share),
    .norm_o (norm)
  );

  tfs_sub_inv #(.STYLE(STYLE)) u_inv (
    .d_i  (norm),
    .inv_o(theta)
  );

  tfs_out_stage #(.STYLE(STYLE)) u_out (
    .theta_i(theta),
    .a_i    (share[SUB_W-1:0]),
    .b_i    (share[BYTE_W-1:SUB_W]),
    .sbox_o (sbox_o)
  );

  always_comb begin
    a_r4_no_fixed: assert (sbox_o != byte_i && sbox_o != ~byte_i)
      else $error("R4: fixed or complement-fixed point");
  end
endmodule

// File: tb/tb_tfs_sbox.sv
module tb_tfs_sbox;
  import tfs_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] sbox_o, sbox_area;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tfs_sbox #(.STYLE(STYLE_SPEED)) dut      (.byte_i(byte_i), .sbox_o(sbox_o));
  tfs_sbox #(.STYLE(STYLE_AREA))  dut_area (.byte_i(byte_i), .sbox_o(sbox_area));

  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011B << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] q = '0;
    logic [7:0] s;
    for (int t = 1; t < 256; t++) if (ref_mul(x, t[7:0]) == 8'h01) q = t[7:0];
    for (int i = 0; i < 8; i++)
      s[i] = q[i] ^ q[(i+4)%8] ^ q[(i+5)%8] ^ q[(i+6)%8] ^ q[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: in=%02h got=%02h expected=%02h", tag, byte_i, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(posedge clk);
    #2 byte_i = v;
    #2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [255:0] seen;
    int unsigned  seed;
    logic [7:0]   r;
    seen = '0;
    seed = 32'h5B0C_1E37;
    r    = 8'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R2 reset-time state: zero byte
    #2 check("R2 zero", sbox_o, 8'h63);

    // R3 spot values
    apply(8'h01); check("R3", sbox_o, 8'h7C);
    apply(8'h53); check("R3", sbox_o, 8'hED);
    apply(8'h80); check("R3", sbox_o, 8'hCD);
    apply(8'hFF); check("R3", sbox_o, 8'h16);
    apply(8'h00); check("R2", sbox_o, 8'h63);
    check("R6 zero", sbox_area, 8'h63);

    // R7: change input mid-cycle, read back before the next edge
    @(negedge clk);
    byte_i = 8'h53; #1 check("R7", sbox_o, 8'hED);
    byte_i = 8'h01; #1 check("R7", sbox_o, 8'h7C);

    // full sweep: R1, R4, R5, R6; internal checks R8 R9 R10 R11 fire here too
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      apply(v[7:0]);
      e = ref_sbox(v[7:0]);
      check("R1/R8/R9/R10/R11", sbox_o, e);
      check("R6", sbox_area, sbox_o);
      checks++;
      if (sbox_o == byte_i || sbox_o == ~byte_i) begin
        errors++;
        $display("FAIL R4: in=%02h got=%02h expected neither %02h nor %02h",
                 byte_i, sbox_o, byte_i, ~byte_i);
      end
      seen[sbox_o] = 1'b1;
    end
    checks++;
    if (seen !== {256{1'b1}}) begin
      errors++;
      $display("FAIL R5: outputs covered=%0d expected=256", $countones(seen));
    end

    // random order, both styles
    for (int n = 0; n < 400; n++) begin
      logic [7:0] v;
      v = 8'($urandom);
      apply(v);
      check("R1 rand", sbox_o, ref_sbox(v));
      check("R6 rand", sbox_area, ref_sbox(v));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule